// File: doc/BRIEF.md
# Prescaled Timer with Trigger Outputs

An up-counting timer for triggering other blocks of a chip. A programmable prescaler divides the block clock. The main counter steps once per prescaled tick and wraps to zero after it reaches the reload value. Each wrap is an update event. Software can also force an update event. On an update, the buffered prescaler and reload values become active and the count restarts.

There are two trigger outputs, each picked by its own selector field. The main trigger chooses one of these: a software event pulse, the run level, the update pulse, a compare pulse, or one of four compare-reference levels. These references come from an external compare stage. The auxiliary trigger has a wider selector. It adds two more references and six edge-combination pulses that mix references 4 and 5 with both edges of reference 6. A build parameter removes the auxiliary trigger. In that build its selector bits read back as zero, so software can tell whether it exists.

Registers are written through a single-cycle write strobe and read combinationally on the same address bus.

Top module: `trig_timer`

## Requirements
- R1: The register addresses are 0 control, 1 selectors, 2 prescaler, 3 reload, 4 count and 5 event. Control bit 0 is run and bit 1 is reload buffering. In the selector register, bits 2:0 hold the main code and bits 7:4 the auxiliary code. In the event register, bit 0 forces an update. After reset every register reads zero and both triggers are low.
- R2: While run is 1, update events repeat every (prescaler+1)*(reload+1) clock cycles.
- R3: While run is 0, the count holds its value. A write to the count register loads the count directly, and a read returns it.
- R4: With reload buffering set, a reload write changes the period only from the next update event on. A prescaler write always waits for the next update event.
- R5: With reload buffering clear, a reload write takes effect at once for the period in progress.
- R6: Writing 1 to event bit 0 zeroes the count and the prescaler counter and loads both buffered values. It also raises an update event. The event register reads zero.
- R7: Main trigger codes are as follows:
  - 0: a one-cycle pulse only on a forced update.
  - 1: the run level.
  - 2: a one-cycle pulse on every update.
  - 3: a pulse on a rising edge of reference 1.
  - 4 to 7: the level of reference 1 to 4.
  
  Update pulses appear in the cycle that follows the update clock edge. Edges are detected against the reference value at the previous clock edge.
- R8: Auxiliary codes 0 to 7 behave as on the main trigger. Codes 8 and 9 give the levels of references 5 and 6.
- R9: Auxiliary codes 10 to 15 give edge pulses, as follows:
  - 10: rise of reference 4.
  - 11: rise of reference 6.
  - 12: rise of reference 4 or rise of reference 6.
  - 13: rise of reference 4 or fall of reference 6.
  - 14: rise of reference 5 or rise of reference 6.
  - 15: rise of reference 5 or fall of reference 6.
- R10: Without the auxiliary trigger, selector bits 7:4 read zero after any write and the auxiliary output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data of the addressed register |
| cmp_ref | input | REF_N | Compare references from the external compare stage |
| trig_main | output | 1 | Main trigger output |
| trig_aux | output | 1 | Auxiliary trigger output |

## Verification
Random prescaler and reload pairs are run, and the gap between update pulses is measured. A single wrong product term or an off-by-one in either divider shows up as a wrong gap. The period is then changed in the middle of a run, once with buffering on and once with it off. The gap seen on the next period shows whether the new value was held back or applied at once. Random reference patterns are driven against every selector code, and the edge codes show whether rise and fall are taken against the previous clock edge. The build without the auxiliary trigger is written with a full selector byte to show that the missing field reads zero.

// File: rtl/trig_timer_pkg.sv
package trig_timer_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      REG_CTRL = 3'd0,
      REG_SEL  = 3'd1,
      REG_PSC  = 3'd2,
      REG_RLD  = 3'd3,
      REG_CNT  = 3'd4,
      REG_EVT  = 3'd5
   } reg_addr_e;

   localparam int CTRL_RUN = 0;
   localparam int CTRL_BUF = 1;
   localparam int SEL_AUX_LSB = 4;

   // base codes (low three selector bits, top bit clear)
   localparam logic [2:0] MM_SWEVT  = 3'd0;
   localparam logic [2:0] MM_RUN    = 3'd1;
   localparam logic [2:0] MM_UPD    = 3'd2;
   localparam logic [2:0] MM_CPULSE = 3'd3;

   // extended codes (low three bits, top bit set)
   localparam logic [2:0] MX_REF5   = 3'd0;
   localparam logic [2:0] MX_REF6   = 3'd1;
   localparam logic [2:0] MX_R4     = 3'd2;
   localparam logic [2:0] MX_R6     = 3'd3;
   localparam logic [2:0] MX_R4R6   = 3'd4;
   localparam logic [2:0] MX_R4F6   = 3'd5;
   localparam logic [2:0] MX_R5R6   = 3'd6;
   localparam logic [2:0] MX_R5F6   = 3'd7;
endpackage

// File: rtl/trig_timer_regs.sv
module trig_timer_regs
   import trig_timer_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int CNT_W    = 16,
   parameter int PSC_W    = 16,
   parameter bit HAS_TRG2 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  cnt,
   output logic [DATA_W-1:0] rdata,
   output logic              run,
   output logic              preload,
   output logic [2:0]        sel1,
   output logic [3:0]        sel2,
   output logic [PSC_W-1:0]  psc_buf,
   output logic [CNT_W-1:0]  rld_buf,
   output logic              cnt_wr,
   output logic              rld_wr,
   output logic              sw_upd
);
   reg_addr_e a;
   assign a = reg_addr_e'(addr);

   logic wr_ctrl, wr_sel;
   assign wr_ctrl = wr_en && (a == REG_CTRL);
   assign wr_sel  = wr_en && (a == REG_SEL);
   assign cnt_wr  = wr_en && (a == REG_CNT);
   assign rld_wr  = wr_en && (a == REG_RLD);
   assign sw_upd  = wr_en && (a == REG_EVT) && wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run     <= 1'b0;
         preload <= 1'b0;
         sel1    <= '0;
         psc_buf <= '0;
         rld_buf <= '0;
      end else begin
         if (wr_ctrl) begin
            run     <= wdata[CTRL_RUN];
            preload <= wdata[CTRL_BUF];
         end
         if (wr_sel)
            sel1 <= wdata[2:0];
         if (wr_en && (a == REG_PSC))
            psc_buf <= wdata[PSC_W-1:0];
         if (rld_wr)
            rld_buf <= wdata[CNT_W-1:0];
      end
   end

   generate
      if (HAS_TRG2) begin : g_sel2
         logic [3:0] sel2_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sel2_q <= '0;
            else if (wr_sel)
               sel2_q <= wdata[SEL_AUX_LSB +: 4];
         end
         assign sel2 = sel2_q;
      end else begin : g_nosel2
         assign sel2 = '0;
      end
   endgenerate

   always_comb begin
      rdata = '0;
      case (a)
         REG_CTRL: begin
            rdata[CTRL_RUN] = run;
            rdata[CTRL_BUF] = preload;
         end
         REG_SEL: begin
            rdata[2:0]               = sel1;
            rdata[SEL_AUX_LSB +: 4]  = sel2;
         end
         REG_PSC: rdata = DATA_W'(psc_buf);
         REG_RLD: rdata = DATA_W'(rld_buf);
         REG_CNT: rdata = DATA_W'(cnt);
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/trig_timer_count.sv
module trig_timer_count #(
   parameter int CNT_W = 16,
   parameter int PSC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             preload,
   input  logic             sw_upd,
   input  logic             cnt_wr,
   input  logic             rld_wr,
   input  logic [CNT_W-1:0] wr_val,
   input  logic [PSC_W-1:0] psc_buf,
   input  logic [CNT_W-1:0] rld_buf,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] arr_act,
   output logic             upd_q,
   output logic             sw_q
);
   logic [PSC_W-1:0] psc_act, psc_cnt;
   logic tick, wrap, upd_now;

   assign tick    = run && (psc_cnt == psc_act);
   assign wrap    = tick && (cnt == arr_act);
   assign upd_now = sw_upd || wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_cnt <= '0;
         psc_act <= '0;
         cnt     <= '0;
         arr_act <= '0;
         upd_q   <= 1'b0;
         sw_q    <= 1'b0;
      end else begin
         if (sw_upd)
            psc_cnt <= '0;
         else if (run)
            psc_cnt <= tick ? '0 : psc_cnt + 1'b1;

         if (sw_upd)
            cnt <= '0;
         else if (cnt_wr)
            cnt <= wr_val;
         else if (tick)
            cnt <= wrap ? '0 : cnt + 1'b1;

         if (upd_now)
            psc_act <= psc_buf;

         if (rld_wr && !preload)
            arr_act <= wr_val;
         else if (upd_now)
            arr_act <= rld_buf;

         upd_q <= upd_now;
         sw_q  <= sw_upd;
      end
   end
endmodule

// File: rtl/trig_timer_trgmux.sv
module trig_timer_trgmux
   import trig_timer_pkg::*;
#(
   parameter int SEL_W = 3,
   parameter int NREF  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic             run,
   input  logic             upd,
   input  logic             swevt,
   input  logic [NREF-1:0]  refs,
   output logic             trg
);
   initial begin
      assert (NREF >= 4) else $error("trgmux needs four references");
      assert (SEL_W == 3 || (SEL_W == 4 && NREF >= 6))
         else $error("trgmux selector width and reference count disagree");
   end

   logic q0, rise0, base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q0 <= 1'b0;
      else        q0 <= refs[0];
   end
   assign rise0 = refs[0] & ~q0;

   always_comb begin
      case (sel[2:0])
         MM_SWEVT:  base = swevt;
         MM_RUN:    base = run;
         MM_UPD:    base = upd;
         MM_CPULSE: base = rise0;
         default:   base = refs[sel[1:0]];
      endcase
   end

   generate
      if (SEL_W == 4) begin : g_ext
         logic q3, q4, q5;
         logic r3, r4, r5, f5, ext;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q3 <= 1'b0;
               q4 <= 1'b0;
               q5 <= 1'b0;
            end else begin
               q3 <= refs[3];
               q4 <= refs[4];
               q5 <= refs[5];
            end
         end
         assign r3 = refs[3] & ~q3;
         assign r4 = refs[4] & ~q4;
         assign r5 = refs[5] & ~q5;
         assign f5 = ~refs[5] & q5;
         always_comb begin
            case (sel[2:0])
               MX_REF5: ext = refs[4];
               MX_REF6: ext = refs[5];
               MX_R4:   ext = r3;
               MX_R6:   ext = r5;
               MX_R4R6: ext = r3 | r5;
               MX_R4F6: ext = r3 | f5;
               MX_R5R6: ext = r4 | r5;
               default: ext = r4 | f5;
            endcase
         end
         assign trg = sel[SEL_W-1] ? ext : base;
      end else begin : g_base
         assign trg = base;
      end
   endgenerate
endmodule

// File: rtl/trig_timer.sv
module trig_timer
   import trig_timer_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int CNT_W    = 16,
   parameter int PSC_W    = 16,
   parameter bit HAS_TRG2 = 1'b1,
   parameter int REF_N    = HAS_TRG2 ? 6 : 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [REF_N-1:0]  cmp_ref,
   output logic              trig_main,
   output logic              trig_aux
);
   initial begin
      assert (DATA_W >= 8) else $error("DATA_W must hold the selector byte");
      assert (CNT_W <= DATA_W && CNT_W >= 2) else $error("CNT_W out of range");
      assert (PSC_W <= DATA_W && PSC_W >= 1) else $error("PSC_W out of range");
      assert (REF_N == (HAS_TRG2 ? 6 : 4)) else $error("REF_N must match HAS_TRG2");
   end

   logic             run, preload, cnt_wr, rld_wr, sw_upd, upd_q, sw_q;
   logic [2:0]       sel1;
   logic [3:0]       sel2;
   logic [PSC_W-1:0] psc_buf;
   logic [CNT_W-1:0] rld_buf, cnt_q, arr_act;

   trig_timer_regs #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W), .HAS_TRG2(HAS_TRG2)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .cnt(cnt_q), .rdata(rdata), .run(run), .preload(preload),
      .sel1(sel1), .sel2(sel2), .psc_buf(psc_buf), .rld_buf(rld_buf),
      .cnt_wr(cnt_wr), .rld_wr(rld_wr), .sw_upd(sw_upd)
   );

   trig_timer_count #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_count (
      .clk(clk), .rst_n(rst_n), .run(run), .preload(preload),
      .sw_upd(sw_upd), .cnt_wr(cnt_wr), .rld_wr(rld_wr),
      .wr_val(wdata[CNT_W-1:0]), .psc_buf(psc_buf), .rld_buf(rld_buf),
      .cnt(cnt_q), .arr_act(arr_act), .upd_q(upd_q), .sw_q(sw_q)
   );

   trig_timer_trgmux #(.SEL_W(3), .NREF(4)) u_main (
      .clk(clk), .rst_n(rst_n), .sel(sel1), .run(run), .upd(upd_q),
      .swevt(sw_q), .refs(cmp_ref[3:0]), .trg(trig_main)
   );

   generate
      if (HAS_TRG2) begin : g_aux
         trig_timer_trgmux #(.SEL_W(4), .NREF(REF_N)) u_aux (
            .clk(clk), .rst_n(rst_n), .sel(sel2), .run(run), .upd(upd_q),
            .swevt(sw_q), .refs(cmp_ref), .trg(trig_aux)
         );
      end else begin : g_noaux
         assign trig_aux = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/trig_timer_chk.sv
module trig_timer_chk
   import trig_timer_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [2:0]       addr,
   input logic             wdata0,
   input logic             run,
   input logic             preload,
   input logic [2:0]       sel1,
   input logic             trig_main,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] arr_act,
   input logic             upd_q
);
   // R3: a stopped counter without a count or event write keeps its value
   p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !(wr_en && (addr == REG_CNT || addr == REG_EVT))) |=> $stable(cnt));

   // R6: a forced update leaves the count at zero
   p_swupd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_EVT && wdata0) |=> (cnt == '0));

   // R7: code 1 on the main trigger follows the run bit
   p_main_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel1 == MM_RUN) |-> (trig_main == run));

   // R4: with buffering, the active reload only moves together with an update
   p_preload_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(preload) && !$stable(arr_act)) |-> upd_q);
endmodule

bind trig_timer trig_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata0(wdata[0]),
   .run(run), .preload(preload), .sel1(sel1), .trig_main(trig_main),
   .cnt(cnt_q), .arr_act(arr_act), .upd_q(upd_q)
);

// File: tb/test_trig_timer.sv
`timescale 1ns/1ps
module test_trig_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [15:0] wdata = 16'd0;
   logic [15:0] rdata, rdata_l;
   logic [5:0]  cmp_ref = 6'd0;
   logic        trig_main, trig_aux, trig_main_l, trig_aux_l;

   int total = 0;
   int bad = 0;
   int cyc = 0, last1 = 0, last2 = 0, gap1 = 0, gap2 = 0, n1 = 0, n2 = 0;

   always #4 clk = ~clk;

   trig_timer i_trig_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .cmp_ref(cmp_ref), .trig_main(trig_main), .trig_aux(trig_aux)
   );

   trig_timer #(.HAS_TRG2(1'b0)) i_trig_timer_lite (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata_l), .cmp_ref(cmp_ref[3:0]), .trig_main(trig_main_l),
      .trig_aux(trig_aux_l)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         cyc <= cyc + 1;
         if (trig_main) begin gap1 <= cyc + 1 - last1; last1 <= cyc + 1; n1 <= n1 + 1; end
         if (trig_aux)  begin gap2 <= cyc + 1 - last2; last2 <= cyc + 1; n2 <= n2 + 1; end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d, output logic [15:0] dl);
      @(negedge clk);
      addr = a;
      #1;
      d = rdata;
      dl = rdata_l;
   endtask

   task automatic wait_main;
      int k;
      k = n1;
      while (n1 == k) begin @(negedge clk); #1; end
   endtask

   function automatic logic model(input int code, input logic [5:0] r, input logic [5:0] p);
      logic [5:0] ri, fa;
      ri = r & ~p;
      fa = ~r & p;
      case (code)
         3:  return ri[0];
         4, 5, 6, 7: return r[code-4];
         8:  return r[4];
         9:  return r[5];
         10: return ri[3];
         11: return ri[5];
         12: return ri[3] | ri[5];
         13: return ri[3] | fa[5];
         14: return ri[4] | ri[5];
         default: return ri[4] | fa[5];
      endcase
   endfunction

   task automatic setup(input int p, input int a, input logic buf_on, input logic [15:0] sel);
      wr(3'd0, {14'd0, buf_on, 1'b0});
      wr(3'd2, 16'(p));
      wr(3'd3, 16'(a));
      wr(3'd1, sel);
      wr(3'd5, 16'd1);
      wr(3'd0, {14'd0, buf_on, 1'b1});
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL R2 watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [15:0] d, dl;
      logic [5:0]  prev, r;
      int k;
      void'($urandom(32'd20250611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), d, dl);
         chk($sformatf("R1 reset reg %0d", a), int'(d), 0);
      end
      chk("R1 reset trig_main", int'(trig_main), 0);
      chk("R1 reset trig_aux", int'(trig_aux), 0);

      // R3 direct count write while stopped
      wr(3'd4, 16'd9);
      rd(3'd4, d, dl);
      chk("R3 count write readback", int'(d), 9);
      repeat (5) @(negedge clk);
      rd(3'd4, d, dl);
      chk("R3 count holds while stopped", int'(d), 9);

      // R6 forced update
      k = n1;
      wr(3'd5, 16'd1);
      repeat (2) @(negedge clk);
      rd(3'd4, d, dl);
      chk("R6 count zero after forced update", int'(d), 0);
      rd(3'd5, d, dl);
      chk("R6 event register reads zero", int'(d), 0);
      chk("R7 code 0 pulse on forced update", n1 - k, 1);

      // R2 random periods, R8 code 2 on the auxiliary output
      for (int i = 0; i < 6; i++) begin
         int p, a;
         p = int'($urandom % 4);
         a = int'($urandom % 7);
         setup(p, a, 1'b0, 16'h0022);
         wait_main;
         wait_main;
         chk($sformatf("R2 period p=%0d a=%0d", p, a), gap1, (p + 1) * (a + 1));
         chk("R8 aux code 2 period", gap2, (p + 1) * (a + 1));
      end
      setup(0, 0, 1'b0, 16'h0022);
      wait_main;
      wait_main;
      chk("R2 corner period of one cycle", gap1, 1);

      // R4 buffered reload and prescaler
      setup(0, 3, 1'b1, 16'h0022);
      wait_main;
      wait_main;
      chk("R4 base period", gap1, 4);
      wr(3'd3, 16'd7);
      wait_main;
      chk("R4 reload held until update", gap1, 4);
      wait_main;
      chk("R4 reload applied after update", gap1, 8);
      rd(3'd3, d, dl);
      chk("R4 reload readback", int'(d), 7);
      wr(3'd2, 16'd1);
      wait_main;
      chk("R4 prescaler held until update", gap1, 8);
      wait_main;
      chk("R4 prescaler applied after update", gap1, 16);

      // R5 direct reload
      setup(0, 3, 1'b0, 16'h0022);
      wait_main;
      wait_main;
      wr(3'd3, 16'd7);
      wait_main;
      chk("R5 reload applied at once", gap1, 8);

      // R7 code 0 ignores natural updates
      setup(0, 1, 1'b0, 16'h0000);
      repeat (3) @(negedge clk);
      k = n1;
      repeat (20) @(negedge clk);
      chk("R7 code 0 silent on natural updates", n1 - k, 0);
      wr(3'd5, 16'd1);
      repeat (2) @(negedge clk);
      chk("R7 code 0 one pulse per forced update", n1 - k, 1);

      // R7 code 1 follows run
      wr(3'd1, 16'h0001);
      @(negedge clk); #1;
      chk("R7 code 1 with run set", int'(trig_main), 1);
      wr(3'd0, 16'd0);
      @(negedge clk); #1;
      chk("R7 code 1 with run clear", int'(trig_main), 0);

      // R3 hold after stop
      rd(3'd4, d, dl);
      k = int'(d);
      repeat (10) @(negedge clk);
      rd(3'd4, d, dl);
      chk("R3 stopped count stable", int'(d), k);

      // R7 main codes 3..7 and R8/R9 aux codes 3..15 with random references
      prev = cmp_ref;
      for (int c = 3; c < 16; c++) begin
         int errs1, errs2;
         errs1 = 0; errs2 = 0;
         wr(3'd1, 16'((c << 4) | (c < 8 ? c : 3)));
         prev = cmp_ref;
         for (int s = 0; s < 24; s++) begin
            @(negedge clk);
            r = 6'($urandom);
            cmp_ref = r;
            #1;
            if (trig_aux !== model(c, r, prev)) errs2++;
            if (trig_main !== model(c < 8 ? c : 3, r, prev)) errs1++;
            if (trig_aux_l !== 1'b0) errs2 += 100;
            prev = r;
         end
         if (c < 8)
            chk($sformatf("R7 main code %0d mismatches", c), errs1, 0);
         if (c < 10)
            chk($sformatf("R8 aux code %0d mismatches", c), errs2, 0);
         else
            chk($sformatf("R9 aux code %0d mismatches", c), errs2, 0);
      end
      cmp_ref = 6'd0;

      // R10 build without the auxiliary trigger
      wr(3'd1, 16'h00F7);
      rd(3'd1, d, dl);
      chk("R10 lite selector readback", int'(dl), 16'h0007);
      chk("R10 full selector readback", int'(d), 16'h00F7);
      chk("R10 lite aux output low", int'(trig_aux_l), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule